// File: doc/BRIEF.md
# External Clock Loss and Start-Up Supervisor

This block supervises an external clock with the help of a slower internal reference clock. During each low phase of the reference, the external clock must show at least one falling edge. The reference always runs at less than half the external frequency, so a healthy clock always meets this rule. If two reference low phases in a row pass with no external falling edge, the block raises a loss flag. The flag drops again as soon as an external falling edge arrives while the reference is low.

The block also times the start-up of the external clock. When the generator enable goes high, a counter clocked on external falling edges begins to run. The delay is long for a crystal and short for a ready-made clock input. When the count completes, the stable flag rises. The flag falls at once when the enable drops. A detected loss also clears it and holds the counter idle. When the clock returns, the flag needs a full new count before it rises again.

The loss side has three states. `MON_OK` moves to `MON_ONE_MISS` on a missed phase. `MON_ONE_MISS` moves to `MON_LOST` on a second miss, or back to `MON_OK` on a seen edge. `MON_LOST` returns to `MON_OK` on a seen edge. The timer side also has three states. `TMR_IDLE` moves to `TMR_COUNT` on an enabled edge, which also latches the length. `TMR_COUNT` moves to `TMR_DONE` when the count ends. Any state returns to `TMR_IDLE` when the enable is low. A loss resets the timer to `TMR_IDLE` asynchronously.

Top module: `xclk_supervisor`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `ext_lost` and `ext_stable` are both 0.
- R2: `ext_lost` becomes 1 right after the second consecutive rising edge of `ref_clk` whose preceding low phase held no `ext_clk` falling edge. A single such phase leaves it at 0.
- R3: While lost, the first `ext_clk` falling edge that occurs with `ref_clk` low drives `ext_lost` to 0 immediately.
- R4: `ext_clk` falling edges while `ref_clk` is high neither clear `ext_lost` nor count as activity.
- R5: With `xtal_sel`=1 when enabled, `ext_stable` rises right after the 4096th `ext_clk` falling edge that samples `ext_en` high, and not after the 4095th.
- R6: With `xtal_sel`=0 when enabled, `ext_stable` rises right after the 16th such edge, and not after the 15th.
- R7: `ext_en`=0 drives `ext_stable` to 0 at once and holds the timer idle. Raising it again restarts a full count.
- R8: When `ext_lost` rises, `ext_stable` falls. After activity resumes and the loss state clears at a `ref_clk` rising edge, `ext_stable` needs a full new count of falling edges.
- R9: A change of `xtal_sel` during a count does not change that count's length. The value is sampled only when a count starts.
- R10: Once set, `ext_stable` stays 1 while `ext_en` is high and the clock keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_clk | input | 1 | External clock under supervision |
| ref_clk | input | 1 | Internal reference, under half the external frequency |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_en | input | 1 | External generator enable (low also in stop mode) |
| xtal_sel | input | 1 | 1 selects the long (crystal) start-up delay, 0 the short one |
| ext_lost | output | 1 | External clock inactivity flag |
| ext_stable | output | 1 | External clock stable flag |

## Verification
The loss flag and the stable flag collide when the clock stops while the stable flag is up: the loss must pull the stable flag down in the same instant and block its counter. The bench first brings the stable flag up, then stops the external clock during a reference high phase. It checks that the stable flag is still 1 after the first missed phase, and that both flags change together after the second. It then restarts the clock and counts the exact number of falling edges needed before the stable flag returns. A random sequence of running and stopped phases is also judged against a bench miss-count model.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

    typedef enum logic [1:0] {
        MON_OK       = 2'd0,
        MON_ONE_MISS = 2'd1,
        MON_LOST     = 2'd2
    } mon_state_e;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_DONE  = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/xcs_activity_mon.sv
// Loss detector: an external-domain token is compared with a reference-domain
// expectation at every reference rising edge (end of a low phase).
module xcs_activity_mon
    import xcs_pkg::*;
(
    input  logic ext_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic lost_o,
    output logic lost_q_o
);

    logic       mark_q;
    logic       want_q;
    logic       seen;
    mon_state_e state_q;
    mon_state_e state_d;

    // External domain: stamp the expected token on a falling edge in the low phase
    always_ff @(negedge ext_clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
        end else if (!ref_clk) begin
            mark_q <= want_q;
        end
    end

    assign seen = (mark_q == want_q);

    // Reference domain: state register and token flip
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_OK;
            want_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (seen) begin
                want_q <= ~want_q;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OK:       if (!seen) state_d = MON_ONE_MISS;
            MON_ONE_MISS: state_d = seen ? MON_OK : MON_LOST;
            MON_LOST:     if (seen) state_d = MON_OK;
            default:      state_d = MON_OK;
        endcase
    end

    // Outputs: the flag drops as soon as a fresh token lands
    always_comb begin
        lost_q_o = (state_q == MON_LOST);
        lost_o   = lost_q_o && !seen;
    end

    assert_two_misses_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == MON_ONE_MISS && mark_q != want_q) |=> (state_q == MON_LOST));

    assert_seen_recovers_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mark_q == want_q) |=> (state_q == MON_OK));

endmodule

// File: rtl/xcs_startup_timer.sv
// Start-up counter on external falling edges; the length is latched at start.
module xcs_startup_timer
    import xcs_pkg::*;
#(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 16
) (
    input  logic ext_clk,
    input  logic arst_n,
    input  logic en_i,
    input  logic xtal_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(LONG_CYCLES);
    localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYCLES - 1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;

    always_ff @(negedge ext_clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
            lim_q   <= SHORT_M1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        if (!en_i) begin
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    state_d = TMR_COUNT;
                    cnt_d   = CNT_W'(1);
                    lim_d   = xtal_i ? LONG_M1 : SHORT_M1;
                end
                TMR_COUNT: begin
                    if (cnt_q == lim_q) state_d = TMR_DONE;
                    else                cnt_d   = cnt_q + 1'b1;
                end
                TMR_DONE: begin
                    state_d = TMR_DONE;
                end
                default: state_d = TMR_IDLE;
            endcase
        end
    end

    always_comb begin
        done_o = (state_q == TMR_DONE);
    end

    assert_disable_idles_R7: assert property (@(negedge ext_clk) disable iff (!arst_n)
        !en_i |=> (state_q == TMR_IDLE));

    assert_count_steps_R5: assert property (@(negedge ext_clk) disable iff (!arst_n)
        (state_q == TMR_COUNT && en_i) |=>
            (state_q == TMR_DONE || cnt_q == $past(cnt_q) + 1'b1));

    assert_limit_frozen_R9: assert property (@(negedge ext_clk) disable iff (!arst_n)
        (state_q == TMR_COUNT) |=> $stable(lim_q));

    assert_done_holds_R10: assert property (@(negedge ext_clk) disable iff (!arst_n)
        (state_q == TMR_DONE && en_i) |=> (state_q == TMR_DONE));

endmodule

// File: rtl/xclk_supervisor.sv
module xclk_supervisor #(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 16
) (
    input  logic ext_clk,
    input  logic ref_clk,
    input  logic rst_n,
    input  logic ext_en,
    input  logic xtal_sel,
    output logic ext_lost,
    output logic ext_stable
);

    logic lost_flag;
    logic lost_state;
    logic tmr_arst_n;
    logic tmr_done;

    xcs_activity_mon i_mon (
        .ext_clk  (ext_clk),
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .lost_o   (lost_flag),
        .lost_q_o (lost_state)
    );

    // A registered loss holds the start-up timer idle
    assign tmr_arst_n = rst_n & ~lost_state;

    xcs_startup_timer #(
        .LONG_CYCLES  (LONG_CYCLES),
        .SHORT_CYCLES (SHORT_CYCLES)
    ) i_tmr (
        .ext_clk (ext_clk),
        .arst_n  (tmr_arst_n),
        .en_i    (ext_en),
        .xtal_i  (xtal_sel),
        .done_o  (tmr_done)
    );

    always_comb begin
        ext_lost   = lost_flag;
        ext_stable = tmr_done & ext_en;
    end

    assert_lost_blocks_stable_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ext_lost |-> !ext_stable);

endmodule

// File: tb/test_xclk_supervisor.sv
`timescale 1ns/100ps
module test_xclk_supervisor;

    logic ext_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic ext_en  = 1'b0;
    logic xtal_sel = 1'b0;
    logic ext_run = 1'b1;
    logic ext_lost;
    logic ext_stable;

    int errors = 0;
    int checks = 0;

    xclk_supervisor i_xclk_supervisor (
        .ext_clk    (ext_clk),
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .ext_en     (ext_en),
        .xtal_sel   (xtal_sel),
        .ext_lost   (ext_lost),
        .ext_stable (ext_stable)
    );

    // 250 MHz external clock that can be stopped low
    always #2 if (ext_run) ext_clk = ~ext_clk;

    // Reference: 40 ns period, edges on odd nanoseconds
    initial begin
        #1;
        forever #20 ref_clk = ~ref_clk;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    function automatic int next_miss(input int m, input bit seen);
        if (seen) return 0;
        return (m >= 2) ? 2 : m + 1;
    endfunction

    // Enable was raised just after a falling edge; count n edges from the next one
    task automatic count_stable(input int n, input string req);
        repeat (n - 1) @(negedge ext_clk);
        #0.5 chk(req, ext_stable, 1'b0);
        @(negedge ext_clk);
        #0.5 chk(req, ext_stable, 1'b1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired at %0t: actual=running expected=finished", $time);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int misses;
        bit ran_prev;
        bit run_next;
        void'($urandom(32'd7321));

        // R1: reset state
        #20;
        chk("R1 lost in reset", ext_lost, 1'b0);
        chk("R1 stable in reset", ext_stable, 1'b0);
        #30 rst_n = 1'b1;
        #0.5;
        chk("R1 lost after reset", ext_lost, 1'b0);
        chk("R1 stable after reset", ext_stable, 1'b0);

        // R6: short delay
        @(negedge ext_clk);
        #0.5 xtal_sel = 1'b0; ext_en = 1'b1;
        count_stable(16, "R6");

        // R10: stays set
        repeat (50) @(negedge ext_clk);
        #0.5 chk("R10 stable held", ext_stable, 1'b1);

        // R7: disable drops and restarts
        ext_en = 1'b0;
        #0.2 chk("R7 stable drops on disable", ext_stable, 1'b0);
        repeat (3) @(negedge ext_clk);
        #0.5 chk("R7 stable stays low", ext_stable, 1'b0);
        ext_en = 1'b1;
        count_stable(16, "R7");

        // R9: crystal bit changed mid-count has no effect
        ext_en = 1'b0;
        @(negedge ext_clk);
        #0.5 xtal_sel = 1'b0; ext_en = 1'b1;
        repeat (5) @(negedge ext_clk);
        #0.5 xtal_sel = 1'b1;
        repeat (10) @(negedge ext_clk);
        #0.5 chk("R9 not before 16", ext_stable, 1'b0);
        @(negedge ext_clk);
        #0.5 chk("R9 at 16 despite change", ext_stable, 1'b1);

        // R5: long delay
        ext_en = 1'b0;
        @(negedge ext_clk);
        #0.5 ext_en = 1'b1;
        count_stable(4096, "R5");

        // R2/R8/R4/R3: loss while stable, then recovery
        xtal_sel = 1'b0;
        @(posedge ref_clk);
        #0.5;
        @(negedge ext_clk);
        ext_run = 1'b0;
        @(posedge ref_clk);
        #0.5;
        chk("R2 one miss is not loss", ext_lost, 1'b0);
        chk("R8 stable kept after one miss", ext_stable, 1'b1);
        @(posedge ref_clk);
        #0.5;
        chk("R2 loss after two misses", ext_lost, 1'b1);
        chk("R8 stable cleared by loss", ext_stable, 1'b0);
        ext_run = 1'b1;
        #15;
        chk("R4 edges in high phase ignored", ext_lost, 1'b1);
        @(negedge ref_clk);
        @(negedge ext_clk);
        #0.5 chk("R3 cleared by low-phase edge", ext_lost, 1'b0);
        chk("R8 no stable before recount", ext_stable, 1'b0);
        @(posedge ref_clk);
        count_stable(16, "R8");

        // R2 random: running and stopped phases against a miss model
        misses = 0;
        ran_prev = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(posedge ref_clk);
            #0.5;
            misses = next_miss(misses, ran_prev);
            chk("R2 random loss state", ext_lost, (misses >= 2));
            run_next = (($urandom % 3) != 0);
            if (run_next && !ext_run) begin
                ext_run = 1'b1;
            end else if (!run_next && ext_run) begin
                @(negedge ext_clk);
                ext_run = 1'b0;
            end
            ran_prev = run_next;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule